// File: doc/BRIEF.md
# Byte-Lane Load/Store Aligner

This unit sits between a 32-bit core and a 32-bit-wide data memory that gives each 8-bit byte its own address. A request arrives on a single port in one cycle. It carries a byte address, an access width (byte, halfword or word), a signed flag, a per-access byte-order select and, for stores, the value to write in its low-order bits. The unit turns the request into a word address for the memory. A store becomes write data on the lanes plus per-lane write enables. A load becomes a read strobe; the returned word is then sliced, reordered and extended into a 32-bit result.

Each access chooses its own byte order. The unit never splits or merges bytes across two words: an object that does not start on a multiple of its own size is refused, and the unit raises a fault in the same cycle. Load results leave through a register, so the core sees them one cycle after the memory's read word.

Top module: `lane_align_unit`

## Requirements
- R1: `mem_addr` equals `req_addr` with its two low bits cleared. Memory lane j (bits 8j+7..8j of `mem_wdata` and `mem_rdata`) holds the byte at address `mem_addr`+j.
- R2: Width code `req_size` is 0 for byte, 1 for halfword and 2 for word. Code 3 is illegal and always faults.
- R3: When `req_valid` is high, `fault` is high in that same cycle for any of these: a halfword with `req_addr[0]`=1, a word with `req_addr[1:0]`≠0, or width code 3. A faulting request drives `mem_wbe` to zero and `mem_ren` low, so memory is left unchanged and no load result follows. `fault` is low whenever `req_valid` is low.
- R4: An aligned store (`req_store`=1) asserts `mem_wbe` on exactly the lanes its bytes occupy. No enable is asserted for loads or idle cycles.
- R5: Little-endian stores (`req_big`=0) put byte i of the value at address `req_addr`+i. The object is repeated across all four lanes of `mem_wdata`.
- R6: Big-endian stores (`req_big`=1) put the most significant byte of the value at `req_addr`, and the remaining bytes follow in order of decreasing significance. The object is repeated across all four lanes.
- R7: Little-endian loads take the byte at the lowest address as the least significant byte of the result.
- R8: Big-endian loads take the byte at the lowest address as the most significant byte of the object.
- R9: Byte and halfword loads are sign-extended to 32 bits when `req_signed`=1 and zero-extended when it is 0. Word loads ignore the flag.
- R10: An aligned load asserts `mem_ren` in its request cycle. The unit samples `mem_rdata` in the following cycle. `ld_valid` pulses high for one cycle, with `ld_data`, two cycles after the request, and never pulses otherwise.
- R11: While `rst_n` is low at a clock edge, `ld_valid` and `ld_data` clear to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | 16 | Byte address |
| req_size | input | 2 | Width code: 0 byte, 1 halfword, 2 word, 3 illegal |
| req_signed | input | 1 | Sign-extend narrow loads |
| req_big | input | 1 | 1 = big-endian access |
| req_wdata | input | 32 | Store value, right-justified |
| mem_rdata | input | 32 | Memory read word, valid the cycle after `mem_ren` |
| mem_addr | output | 16 | Word-aligned memory address |
| mem_ren | output | 1 | Memory read strobe |
| mem_wbe | output | 4 | Per-lane write enables |
| mem_wdata | output | 32 | Lane-replicated write data |
| fault | output | 1 | Misaligned or illegal access |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |

## Verification
A load's registered result leaves the unit in the same cycle that a later request is being decoded: a store, a second load or a faulting access. The bench issues requests back to back with no idle cycles, mixes widths, byte orders and misaligned addresses, and also stores to a location just before loading it. Every cycle, the write enables, the write data and the fault output are compared with a byte-level model of the request in flight. In the same cycle, `ld_valid` and `ld_data` are compared with the head of a queue of load results that the bench computed two cycles earlier from its own byte memory.

// File: rtl/lane_align_pkg.sv
// Shared definitions for the byte-lane aligner: access width codes and
// the byte count that each width covers.
package lane_align_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    // Number of bytes an access of the given width spans.
    function automatic int size_bytes(acc_size_e s);
        case (s)
            SZ_BYTE: return 1;
            SZ_HALF: return 2;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/lane_align_addr_check.sv
// Alignment checker. It decides whether the request in flight is legal
// and splits it into a store-go or load-go strobe.
// Assumes a 4-lane word: a word access must have a zero lane offset.
module lane_align_addr_check
    import lane_align_pkg::*;
#(
    parameter int OFF_W = 2
) (
    input  logic             req_valid,
    input  logic             req_store,
    input  acc_size_e        req_size,
    input  logic [OFF_W-1:0] req_off,
    output logic             fault,
    output logic             go_store,
    output logic             go_load
);

    logic misaligned;

    // Misalignment test per width; the illegal code is always refused.
    always_comb begin
        case (req_size)
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = req_off[0];
            SZ_WORD: misaligned = |req_off;
            default: misaligned = 1'b1;
        endcase
    end

    // Qualify with the request strobe and steer by direction.
    always_comb begin
        fault    = req_valid & misaligned;
        go_store = req_valid & ~misaligned & req_store;
        go_load  = req_valid & ~misaligned & ~req_store;
    end

endmodule

// File: rtl/lane_align_store_path.sv
// Store lane builder. It repeats the object across every lane in the
// requested byte order and enables only the lanes the object covers.
// Assumes the request was already found aligned (go is low otherwise).
module lane_align_store_path
    import lane_align_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8,
    parameter int OFF_W  = $clog2(LANES)
) (
    input  logic              go,
    input  acc_size_e         size,
    input  logic              big,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] st_data,
    output logic [DATA_W-1:0] wdata,
    output logic [LANES-1:0]  wbe
);

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        int n;
        int k;
        int src;
        int ofs;

        // Pick the source byte for lane j and decide its enable.
        always_comb begin
            n   = size_bytes(size);
            ofs = int'(off);
            k   = j % n;
            src = big ? (n - 1 - k) : k;
            wdata[8*j +: 8] = st_data[8*src +: 8];
            wbe[j] = go && (j >= ofs) && (j < ofs + n);
        end
    end

endmodule

// File: rtl/lane_align_load_path.sv
// Load extractor. It captures the attributes of an issued load, slices
// and reorders the memory word returned on the next cycle, extends it
// and registers the result.
// Assumes memory returns the read word exactly one cycle after the strobe.
module lane_align_load_path
    import lane_align_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8,
    parameter int OFF_W  = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  acc_size_e         size,
    input  logic              sgn,
    input  logic              big,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              ld_valid,
    output logic [DATA_W-1:0] ld_data
);

    logic              s1_valid;
    acc_size_e         s1_size;
    logic              s1_sgn;
    logic              s1_big;
    logic [OFF_W-1:0]  s1_off;
    logic [DATA_W-1:0] ext;
    logic              sbit;
    int                n;
    int                ofs;
    int                lane;

    // Hold the attributes of the load while memory fetches the word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_size  <= SZ_BYTE;
            s1_sgn   <= 1'b0;
            s1_big   <= 1'b0;
            s1_off   <= '0;
        end else begin
            s1_valid <= go;
            s1_size  <= size;
            s1_sgn   <= sgn;
            s1_big   <= big;
            s1_off   <= off;
        end
    end

    // Gather object bytes into result order, then fill the upper bytes.
    always_comb begin
        n    = size_bytes(s1_size);
        ofs  = int'(s1_off);
        ext  = '0;
        lane = 0;
        for (int k = 0; k < LANES; k++) begin
            if (k < n) begin
                lane = (s1_big ? (ofs + n - 1 - k) : (ofs + k)) % LANES;
                ext[8*k +: 8] = mem_rdata[8*lane +: 8];
            end
        end
        sbit = s1_sgn & ext[8*n - 1];
        for (int k = 0; k < LANES; k++) begin
            if (k >= n) ext[8*k +: 8] = {8{sbit}};
        end
    end

    // Register the extended result and its valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_valid <= 1'b0;
            ld_data  <= '0;
        end else begin
            ld_valid <= s1_valid;
            if (s1_valid) ld_data <= ext;
        end
    end

endmodule

// File: rtl/lane_align_unit.sv
// Top of the byte-lane aligner. It joins the alignment checker, the store
// lane builder and the load extractor, and forms the word address.
// Assumes one request per cycle and a memory with one-cycle read latency.
module lane_align_unit
    import lane_align_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_store,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [1:0]           req_size,
    input  logic                 req_signed,
    input  logic                 req_big,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic                 mem_ren,
    output logic [DATA_W/8-1:0]  mem_wbe,
    output logic [DATA_W-1:0]    mem_wdata,
    output logic                 fault,
    output logic                 ld_valid,
    output logic [DATA_W-1:0]    ld_data
);

    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);

    acc_size_e        size_e;
    logic [OFF_W-1:0] off;
    logic             go_store;
    logic             go_load;

    // Decode the width code and split the address.
    always_comb begin
        size_e   = acc_size_e'(req_size);
        off      = req_addr[OFF_W-1:0];
        mem_addr = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        mem_ren  = go_load;
    end

    lane_align_addr_check #(.OFF_W(OFF_W)) u_check (
        .req_valid (req_valid),
        .req_store (req_store),
        .req_size  (size_e),
        .req_off   (off),
        .fault     (fault),
        .go_store  (go_store),
        .go_load   (go_load)
    );

    lane_align_store_path #(.DATA_W(DATA_W), .LANES(LANES), .OFF_W(OFF_W)) u_store (
        .go      (go_store),
        .size    (size_e),
        .big     (req_big),
        .off     (off),
        .st_data (req_wdata),
        .wdata   (mem_wdata),
        .wbe     (mem_wbe)
    );

    lane_align_load_path #(.DATA_W(DATA_W), .LANES(LANES), .OFF_W(OFF_W)) u_load (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go_load),
        .size      (size_e),
        .sgn       (req_signed),
        .big       (req_big),
        .off       (off),
        .mem_rdata (mem_rdata),
        .ld_valid  (ld_valid),
        .ld_data   (ld_data)
    );

endmodule

// File: rtl/lane_align_checker.sv
// Protocol checker for the byte-lane aligner, attached by bind.
// It watches the port-level relations between requests, enables,
// faults and load results.
module lane_align_checker #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_store,
    input logic [1:0]       req_off,
    input logic [1:0]       req_size,
    input logic             mem_ren,
    input logic [LANES-1:0] mem_wbe,
    input logic             fault,
    input logic             ld_valid
);

    a_r3_fault_blocks_memory: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (mem_wbe == '0 && !mem_ren));

    a_r3_no_fault_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !fault);

    a_r2_illegal_code_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'd3) |-> fault);

    a_r4_byte_store_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store && req_size == 2'd0) |-> $countones(mem_wbe) == 1);

    a_r4_word_store_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store && req_size == 2'd2 && req_off == 2'd0) |-> (&mem_wbe));

    a_r4_no_enable_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || !req_store) |-> mem_wbe == '0);

    a_r10_result_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ren |=> ##1 ld_valid);

    a_r10_no_spurious_result: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(mem_ren, 2));

endmodule

bind lane_align_unit lane_align_checker #(.LANES(DATA_W / 8)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_store (req_store),
    .req_off   (req_addr[1:0]),
    .req_size  (req_size),
    .mem_ren   (mem_ren),
    .mem_wbe   (mem_wbe),
    .fault     (fault),
    .ld_valid  (ld_valid)
);

// File: tb/lane_align_unit_bench.sv
`timescale 1ns/1ps
module lane_align_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_store = 1'b0;
    logic [15:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_signed = 1'b0;
    logic        req_big = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [31:0] mem_rdata = '0;
    logic [15:0] mem_addr;
    logic        mem_ren;
    logic [3:0]  mem_wbe;
    logic [31:0] mem_wdata;
    logic        fault;
    logic        ld_valid;
    logic [31:0] ld_data;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 0;

    logic [7:0] phys [0:63];
    logic [7:0] refm [0:63];
    int          due_q [$];
    logic [31:0] val_q [$];
    string       tag_q [$];

    always #4 clk = ~clk;

    lane_align_unit u_lane_align_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_addr(req_addr), .req_size(req_size), .req_signed(req_signed),
        .req_big(req_big), .req_wdata(req_wdata), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_ren(mem_ren), .mem_wbe(mem_wbe),
        .mem_wdata(mem_wdata), .fault(fault), .ld_valid(ld_valid), .ld_data(ld_data)
    );

    // Memory model: one-cycle read, byte-lane writes.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        for (int j = 0; j < 4; j++)
            if (mem_wbe[j]) phys[mem_addr[5:0] + j] <= mem_wdata[8*j +: 8];
        if (mem_ren)
            mem_rdata <= {phys[mem_addr[5:0] + 3], phys[mem_addr[5:0] + 2],
                          phys[mem_addr[5:0] + 1], phys[mem_addr[5:0]]};
    end

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // Compare the registered load port with the queued expectation.
    task automatic check_load_port();
        if (due_q.size() > 0 && due_q[0] == cyc) begin
            chk(ld_valid == 1'b1, "R10", "ld_valid", {31'd0, ld_valid}, 32'd1);
            chk(ld_data == val_q[0], tag_q[0], "ld_data", ld_data, val_q[0]);
            void'(due_q.pop_front());
            void'(val_q.pop_front());
            void'(tag_q.pop_front());
        end else begin
            chk(ld_valid == 1'b0, "R10", "ld_valid idle", {31'd0, ld_valid}, 32'd0);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        req_store = 1'b0;
        #1;
        chk(fault == 1'b0, "R3", "fault idle", {31'd0, fault}, 32'd0);
        chk(mem_wbe == 4'd0 && mem_ren == 1'b0, "R4", "enables idle",
            {27'd0, mem_ren, mem_wbe}, 32'd0);
        check_load_port();
    endtask

    task automatic access(bit st, int a, int sz, bit sg, bit bg, logic [31:0] d);
        int n;
        bit mis;
        logic [3:0]  ewbe;
        logic [31:0] ewd;
        logic [31:0] v;
        logic [7:0]  b;
        string tg;
        @(negedge clk);
        req_valid  = 1'b1;
        req_store  = st;
        req_addr   = 16'(a);
        req_size   = 2'(sz);
        req_signed = sg;
        req_big    = bg;
        req_wdata  = d;
        #1;
        n   = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        mis = (sz == 3) || ((a % n) != 0);
        chk(fault == mis, "R3", "fault", {31'd0, fault}, {31'd0, mis});
        chk(mem_addr == 16'(a & ~3), "R1", "mem_addr", {16'd0, mem_addr}, 32'(a & ~3));
        chk(mem_ren == (!st && !mis), "R10", "mem_ren", {31'd0, mem_ren}, {31'd0, (!st && !mis)});
        ewbe = 4'd0;
        if (st && !mis)
            for (int i = 0; i < n; i++) ewbe[(a + i) % 4] = 1'b1;
        chk(mem_wbe == ewbe, mis ? "R3" : "R4", "mem_wbe", {28'd0, mem_wbe}, {28'd0, ewbe});
        if (st && !mis) begin
            for (int j = 0; j < 4; j++)
                ewd[8*j +: 8] = bg ? d[8*(n - 1 - (j % n)) +: 8] : d[8*(j % n) +: 8];
            chk(mem_wdata == ewd, bg ? "R6" : "R5", "mem_wdata", mem_wdata, ewd);
            for (int i = 0; i < n; i++)
                refm[a + i] = bg ? d[8*(n - 1 - i) +: 8] : d[8*i +: 8];
        end
        check_load_port();
        if (!st && !mis) begin
            v = 32'd0;
            for (int i = 0; i < n; i++) begin
                b = refm[a + i];
                if (bg) v = (v << 8) | {24'd0, b};
                else    v = v | ({24'd0, b} << (8 * i));
            end
            if (n < 4 && sg && v[8*n - 1])
                for (int k = n; k < 4; k++) v[8*k +: 8] = 8'hFF;
            tg = (n < 4) ? "R9" : (bg ? "R8" : "R7");
            due_q.push_back(cyc + 2);
            val_q.push_back(v);
            tag_q.push_back(tg);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R10 watchdog: actual=running expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            phys[i] = 8'(i * 37 + 5);
            refm[i] = 8'(i * 37 + 5);
        end
        // Drive reset for a few edges; the registered outputs must clear.
        req_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(ld_valid == 1'b0, "R11", "ld_valid reset", {31'd0, ld_valid}, 32'd0);
        chk(ld_data == 32'd0, "R11", "ld_data reset", ld_data, 32'd0);
        rst_n = 1'b1;
        idle();

        // R5 R6: word stores in both orders, then read them back in both orders (R7 R8).
        access(1, 0, 2, 0, 0, 32'h11223344);
        access(1, 4, 2, 0, 1, 32'hA1B2C3D4);
        access(0, 0, 2, 0, 0, 0);
        access(0, 0, 2, 0, 1, 0);
        access(0, 4, 2, 1, 0, 0);
        access(0, 4, 2, 0, 1, 0);

        // R4: narrow stores on each legal lane, both orders.
        access(1, 8, 0, 0, 0, 32'h000000C3);
        access(1, 9, 0, 0, 1, 32'h0000007E);
        access(1, 10, 1, 0, 0, 32'h00008001);
        access(1, 14, 1, 0, 1, 32'h0000F00D);
        access(1, 12, 1, 0, 1, 32'h00001234);

        // R9: narrow loads with both extension modes, back to back.
        access(0, 8, 0, 1, 0, 0);
        access(0, 8, 0, 0, 0, 0);
        access(0, 10, 1, 1, 0, 0);
        access(0, 10, 1, 1, 1, 0);
        access(0, 14, 1, 0, 1, 0);
        access(0, 14, 1, 1, 0, 0);

        // R3 R2: misaligned and illegal requests, then show memory untouched.
        access(1, 17, 1, 0, 0, 32'hDEADBEEF);
        access(1, 18, 2, 0, 1, 32'hDEADBEEF);
        access(1, 16, 3, 0, 0, 32'hDEADBEEF);
        access(0, 21, 2, 1, 0, 0);
        access(0, 20, 3, 0, 0, 0);
        access(0, 23, 1, 0, 1, 0);
        access(0, 16, 2, 0, 0, 0);
        idle();

        // R10: store immediately followed by load of the same word.
        access(1, 24, 2, 0, 1, 32'h0BADF00D);
        access(0, 24, 2, 0, 0, 0);
        access(1, 26, 1, 0, 0, 32'h00005A5A);
        access(0, 24, 2, 0, 1, 0);

        // Sweep every offset, width, order and extension mode.
        for (int a = 28; a < 36; a++)
            for (int sz = 0; sz < 4; sz++)
                for (int m = 0; m < 4; m++)
                    access(0, a, sz, m[0], m[1], 0);
        for (int a = 36; a < 44; a++)
            for (int sz = 0; sz < 3; sz++)
                access(1, a, sz, 0, sz[0], 32'(a * 32'h01030507));
        for (int a = 36; a < 44; a++)
            access(0, a & ~3, 2, 0, a[0], 0);

        repeat (4) idle();
        chk(due_q.size() == 0, "R10", "results drained", 32'(due_q.size()), 32'd0);
        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule